// File: doc/BRIEF.md
# Sparse Programmable Routing Switchbox

This block is one switch point of a two-dimensional mesh routing fabric. Four sides meet in it (north, east, south, west), and each side carries `W` routing tracks. The connectivity is deliberately sparse. Track `i` on any side can reach only track `i` on each of the three other sides. That gives six possible switches per track index and `6*W` switches in all, where a full crossbar would need `6*W*W`. Some sets of requested connections therefore cannot be satisfied even when no channel is over capacity. A track can also be configured as a bypass, so that it passes straight through the box without touching any switch.

A pass switch conducts both ways, and that cannot be synthesized. Each track end is therefore split into an input pin and an output pin. Every switch holds two bits. The enable bit turns the switch on. The direction bit chooses which of the two endpoints drives the other, through a multiplexer path. All configuration bits are loaded through a serial shift chain, and the chain's last stage is brought out so that boxes can be daisy-chained. The routing outputs are forced to 0 until the configuration is declared complete. If two enabled switches would drive the same output track, an error flag is raised and the source with the lowest side index is the one that gets through.

Top module: `sbox`

## Requirements
- R1: An active-low asynchronous `rst_n` clears every configuration bit. After reset, `config_out` is 0, `cfg_err` is 0, and every `trk_out` bit is 0 whatever `trk_in` carries, even with `config_done` high.
- R2: On each rising `config_clk` edge with `cfg_shift_en` high, the chain shifts by one place. `config_in` enters bit 0 and every bit k moves to bit k+1. `config_out` always shows bit `13*W-1`. With `cfg_shift_en` low the chain holds. Track t uses bits `13*t` to `13*t+12`: the enable bit of pair p sits at offset `2*p`, its direction bit at `2*p+1`, and the bypass bit at offset 12.
- R3: While `config_done` is low, every `trk_out` bit is 0 and `cfg_err` is 0.
- R4: Side codes are N=0, E=1, S=2, W=3. The pair order is p0=N-E, p1=N-S, p2=N-W, p3=E-S, p4=E-W, p5=S-W. An enabled switch with direction 0 copies the lower-coded side's input to the higher-coded side's output. With direction 1 it copies the higher-coded side's input to the lower-coded side's output.
- R5: Track index i on one side connects only to track index i on the other sides. No input ever appears on an output of a different track index.
- R6: An output track that no enabled switch drives reads 0.
- R7: One input may drive several outputs at once through separate switches, and this does not set `cfg_err`.
- R8: When two or more enabled switches of a non-bypass track point at the same output, `cfg_err` is 1 and that output carries the input of the source side with the lowest code.
- R9: When a track's bypass bit is set, its N and S ends are wired straight to each other, and so are its E and W ends. The track's switch bits are then ignored and it adds nothing to `cfg_err`.
- R10: The routing path is combinational: `trk_out` follows a change of `trk_in` without any `config_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| config_clk | input | 1 | Configuration chain clock |
| rst_n | input | 1 | Asynchronous active-low reset of the chain |
| cfg_shift_en | input | 1 | Shift the chain on this edge |
| config_in | input | 1 | Serial configuration data in |
| config_out | output | 1 | Last chain stage, feeds the next box |
| config_done | input | 1 | Configuration complete, routing enabled |
| trk_in | input | 4*W | Track inputs, bit `side*W + track` |
| trk_out | output | 4*W | Track outputs, bit `side*W + track` |
| cfg_err | output | 1 | Two switches drive one output |

## Verification
The bench loads every single-switch configuration, one track and one direction at a time. For each one it sweeps every input pattern, so a swapped direction bit, a wrong pair order or a leak between track indices shows up as a wrong output bit. Separate cases load a three-way fanout and several drivers converging on one output. A design that flagged fanout, missed a conflict or gave priority to the wrong side would show the wrong `cfg_err` or the wrong winning source. A bypass track is loaded with conflicting switch bits set, which catches a design that still honours those bits or counts them as errors. The chain is read back through `config_out` to catch a reversed or shortened shift order, and the bench checks that outputs stay at zero while `config_done` is low.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int SIDES     = 4;
    localparam int PAIRS     = 6;
    localparam int TRK_BITS  = 2 * PAIRS + 1;
    localparam int BYP_OFS   = 2 * PAIRS;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    // Pair index for two distinct sides, independent of argument order.
    function automatic int pair_of(input int a, input int b);
        int lo;
        int hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        if (lo == 0)      return hi - 1;
        else if (lo == 1) return hi + 1;
        else              return 5;
    endfunction

    // Side across the box, used by bypass tracks.
    function automatic int opposite(input int s);
        return (s + 2) % SIDES;
    endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int LEN = 39
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] bits,
    output logic           dout
);

    typedef struct packed {
        logic [LEN-1:0] sr;
    } chain_t;

    chain_t chain_d;
    chain_t chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) begin
            chain_d.sr = {chain_q.sr[LEN-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign bits = chain_q.sr;
    assign dout = chain_q.sr[LEN-1];

endmodule

// File: rtl/sbox_track.sv
module sbox_track
    import sbox_pkg::*;
(
    input  logic [TRK_BITS-1:0] cfg,
    input  logic                active,
    input  logic [SIDES-1:0]    tin,
    output logic [SIDES-1:0]    tout,
    output logic                err
);

    logic [SIDES-1:0] route_val;
    logic [SIDES-1:0] multi;
    logic             byp;

    assign byp = cfg[BYP_OFS];

    always_comb begin
        route_val = '0;
        multi     = '0;
        for (int d = 0; d < SIDES; d++) begin
            logic [2:0] cnt;
            logic       found;
            cnt   = '0;
            found = 1'b0;
            for (int s = 0; s < SIDES; s++) begin
                if (s != d) begin
                    logic en;
                    logic dir;
                    logic toward;
                    en     = cfg[2 * pair_of(s, d)];
                    dir    = cfg[2 * pair_of(s, d) + 1];
                    toward = (s < d) ? !dir : dir;
                    if (en && toward) begin
                        cnt = cnt + 3'd1;
                        if (!found) begin
                            route_val[d] = tin[s];
                            found        = 1'b1;
                        end
                    end
                end
            end
            multi[d] = (cnt > 3'd1);
        end
    end

    always_comb begin
        tout = '0;
        if (active) begin
            if (byp) begin
                for (int d = 0; d < SIDES; d++) begin
                    tout[d] = tin[opposite(d)];
                end
            end else begin
                tout = route_val;
            end
        end
    end

    assign err = active && !byp && (|multi);

endmodule

// File: rtl/sbox.sv
module sbox
    import sbox_pkg::*;
#(
    parameter int W = 3
) (
    input  logic             config_clk,
    input  logic             rst_n,
    input  logic             cfg_shift_en,
    input  logic             config_in,
    output logic             config_out,
    input  logic             config_done,
    input  logic [4*W-1:0]   trk_in,
    output logic [4*W-1:0]   trk_out,
    output logic             cfg_err
);

    localparam int CFG_LEN = TRK_BITS * W;

    logic [CFG_LEN-1:0] cfg_bits;
    logic [W-1:0]       trk_err;

    sbox_cfg_chain #(.LEN(CFG_LEN)) u_chain (
        .clk      (config_clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (config_in),
        .bits     (cfg_bits),
        .dout     (config_out)
    );

    for (genvar t = 0; t < W; t++) begin : g_trk
        logic [SIDES-1:0] tin_t;
        logic [SIDES-1:0] tout_t;

        for (genvar s = 0; s < SIDES; s++) begin : g_side
            assign tin_t[s]        = trk_in[s*W + t];
            assign trk_out[s*W + t] = tout_t[s];
        end

        sbox_track u_trk (
            .cfg    (cfg_bits[t*TRK_BITS +: TRK_BITS]),
            .active (config_done),
            .tin    (tin_t),
            .tout   (tout_t),
            .err    (trk_err[t])
        );
    end

    assign cfg_err = |trk_err;

endmodule

// File: rtl/sbox_checker.sv
module sbox_checker
    import sbox_pkg::*;
#(
    parameter int W = 3
) (
    input logic                   config_clk,
    input logic                   rst_n,
    input logic                   cfg_shift_en,
    input logic                   config_in,
    input logic                   config_done,
    input logic [4*W-1:0]         trk_in,
    input logic [4*W-1:0]         trk_out,
    input logic                   cfg_err,
    input logic [TRK_BITS*W-1:0]  cfg_bits
);

    assert_idle_zero_R3: assert property (@(posedge config_clk) disable iff (!rst_n)
        !config_done |-> (trk_out == '0 && !cfg_err));

    assert_chain_hold_R2: assert property (@(posedge config_clk) disable iff (!rst_n)
        !cfg_shift_en |=> $stable(cfg_bits));

    assert_chain_entry_R2: assert property (@(posedge config_clk) disable iff (!rst_n)
        cfg_shift_en |=> (cfg_bits[0] == $past(config_in)));

    for (genvar t = 0; t < W; t++) begin : g_byp
        assert_bypass_straight_R9: assert property (@(posedge config_clk) disable iff (!rst_n)
            (config_done && cfg_bits[t*TRK_BITS + BYP_OFS]) |->
            (trk_out[2*W + t] == trk_in[t] && trk_out[t] == trk_in[2*W + t] &&
             trk_out[3*W + t] == trk_in[W + t] && trk_out[W + t] == trk_in[3*W + t]));
    end

endmodule

bind sbox sbox_checker #(.W(W)) u_sbox_checker (
    .config_clk   (config_clk),
    .rst_n        (rst_n),
    .cfg_shift_en (cfg_shift_en),
    .config_in    (config_in),
    .config_done  (config_done),
    .trk_in       (trk_in),
    .trk_out      (trk_out),
    .cfg_err      (cfg_err),
    .cfg_bits     (cfg_bits)
);

// File: tb/tb_sbox.sv
module tb_sbox;

    localparam int W      = 3;
    localparam int TB     = 13;
    localparam int L      = TB * W;
    localparam int NB     = 4 * W;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          shift_en;
    logic          cin;
    logic          cout;
    logic          done;
    logic [NB-1:0] tin;
    logic [NB-1:0] tout;
    logic          err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbox #(.W(W)) dut (
        .config_clk   (clk),
        .rst_n        (rst_n),
        .cfg_shift_en (shift_en),
        .config_in    (cin),
        .config_out   (cout),
        .config_done  (done),
        .trk_in       (tin),
        .trk_out      (tout),
        .cfg_err      (err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Pair numbering from R4: p0 N-E, p1 N-S, p2 N-W, p3 E-S, p4 E-W, p5 S-W.
    function automatic int pidx(input int a, input int b);
        int lo, hi;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        case ({lo[1:0], hi[1:0]})
            4'b0001: return 0;
            4'b0010: return 1;
            4'b0011: return 2;
            4'b0110: return 3;
            4'b0111: return 4;
            default: return 5;
        endcase
    endfunction

    // Set switch from side src to side dst on track t (R2 layout, R4 direction).
    function automatic logic [L-1:0] add_sw(input logic [L-1:0] c, input int t,
                                            input int src, input int dst);
        int p;
        p = pidx(src, dst);
        c[t*TB + 2*p]     = 1'b1;
        c[t*TB + 2*p + 1] = (src > dst);
        return c;
    endfunction

    // Expected outputs from R3, R4, R5, R6, R8, R9.
    function automatic logic [NB-1:0] m_out(input logic [L-1:0] c, input logic [NB-1:0] ti,
                                            input logic dn);
        logic [NB-1:0] o;
        o = '0;
        if (dn) begin
            for (int t = 0; t < W; t++) begin
                for (int d = 0; d < 4; d++) begin
                    if (c[t*TB + 12]) begin
                        o[d*W + t] = ti[((d + 2) % 4)*W + t];
                    end else begin
                        bit got;
                        got = 0;
                        for (int s = 0; s < 4; s++) begin
                            if (s != d && !got) begin
                                int p;
                                p = pidx(s, d);
                                if (c[t*TB + 2*p] && (c[t*TB + 2*p + 1] == (s > d))) begin
                                    o[d*W + t] = ti[s*W + t];
                                    got = 1;
                                end
                            end
                        end
                    end
                end
            end
        end
        return o;
    endfunction

    // Expected error flag from R7, R8, R9.
    function automatic logic m_err(input logic [L-1:0] c, input logic dn);
        logic e;
        e = 1'b0;
        for (int t = 0; t < W; t++) begin
            if (!c[t*TB + 12]) begin
                for (int d = 0; d < 4; d++) begin
                    int n;
                    n = 0;
                    for (int s = 0; s < 4; s++) begin
                        if (s != d) begin
                            int p;
                            p = pidx(s, d);
                            if (c[t*TB + 2*p] && (c[t*TB + 2*p + 1] == (s > d))) n++;
                        end
                    end
                    if (n > 1) e = 1'b1;
                end
            end
        end
        return e && dn;
    endfunction

    task automatic load(input logic [L-1:0] c);
        for (int k = L - 1; k >= 0; k--) begin
            @(negedge clk);
            shift_en = 1'b1;
            cin      = c[k];
        end
        @(negedge clk);
        shift_en = 1'b0;
        cin      = 1'b0;
    endtask

    // Full input sweep without any clock edge (R10).
    task automatic sweep(input string tag, input logic [L-1:0] c);
        for (int v = 0; v < (1 << NB); v++) begin
            tin = v[NB-1:0];
            #1;
            chk(tag, tout, m_out(c, tin, done));
        end
        chk(tag, err, m_err(c, done));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] c;
        rst_n = 1'b0; shift_en = 1'b0; cin = 1'b0; done = 1'b0; tin = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R6: cleared configuration routes nothing.
        done = 1'b1;
        tin  = '1;
        #1;
        chk("R1 outputs", tout, '0);
        chk("R1 config_out", cout, 1'b0);
        chk("R1 cfg_err", err, 1'b0);
        chk("R6 idle outputs", tout, '0);

        // R4 / R5 / R6 / R10: every single switch, both directions.
        for (int t = 0; t < W; t++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    if (a != b) begin
                        done = 1'b0;
                        c = add_sw('0, t, a, b);
                        load(c);
                        done = 1'b1;
                        sweep("R4 R5 R10 single switch", c);
                    end
                end
            end
        end

        // R7: fanout from N on track 1 to all three sides.
        done = 1'b0;
        c = add_sw('0, 1, 0, 1);
        c = add_sw(c, 1, 0, 2);
        c = add_sw(c, 1, 0, 3);
        load(c);
        done = 1'b1;
        sweep("R7 fanout", c);
        chk("R7 no error on fanout", err, 1'b0);

        // R8: N, E and W all drive S on track 0; N wins.
        done = 1'b0;
        c = add_sw('0, 0, 0, 2);
        c = add_sw(c, 0, 1, 2);
        c = add_sw(c, 0, 3, 2);
        load(c);
        done = 1'b1;
        sweep("R8 three drivers", c);
        chk("R8 error flag", err, 1'b1);
        tin = '0; tin[0] = 1'b1; #1;
        chk("R8 N wins", tout[2*W + 0], 1'b1);

        // R3: same conflicting configuration with done low.
        done = 1'b0;
        tin  = '1;
        #1;
        chk("R3 outputs zero", tout, '0);
        chk("R3 error masked", err, 1'b0);
        done = 1'b1;

        // R8: E and W drive S; E wins.
        done = 1'b0;
        c = add_sw('0, 2, 1, 2);
        c = add_sw(c, 2, 3, 2);
        load(c);
        done = 1'b1;
        sweep("R8 E over W", c);
        tin = '0; tin[W + 2] = 1'b1; #1;
        chk("R8 E wins", tout[2*W + 2], 1'b1);

        // R9: bypass track 2 with conflicting switch bits.
        done = 1'b0;
        c = add_sw('0, 2, 1, 2);
        c = add_sw(c, 2, 3, 2);
        c = add_sw(c, 2, 0, 1);
        c[2*TB + 12] = 1'b1;
        load(c);
        done = 1'b1;
        sweep("R9 bypass", c);
        chk("R9 no error", err, 1'b0);

        // R9 with a conflict on another track still flags.
        done = 1'b0;
        c = add_sw(c, 0, 0, 3);
        c = add_sw(c, 0, 2, 3);
        load(c);
        done = 1'b1;
        sweep("R9 bypass plus conflict", c);

        // R2: hold, then shift back out in order.
        done = 1'b0;
        c = '0;
        for (int k = 0; k < L; k++) c[k] = ((k * 7 + 3) % 5) < 2;
        load(c);
        repeat (5) @(negedge clk);
        chk("R2 hold", cout, c[L-1]);
        for (int k = L - 1; k >= 0; k--) begin
            chk("R2 shift order", cout, c[k]);
            shift_en = 1'b1;
            cin      = 1'b0;
            @(negedge clk);
        end
        shift_en = 1'b0;
        #1;
        chk("R2 drained", cout, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule